// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Burst Address Counters

This block is a true dual-port synchronous RAM built from two independent ports, A and B, each with its own clock and reset. Either port may read or write any word at any time, and both may use the same word at once. The word is 18 bits wide and split into two 9-bit byte lanes, each with its own active-low enable. Every input is taken on the rising edge of the port clock. The port clock also completes a write in the cycle the write is taken, so no separate write strobe is needed.

Each port forms its access address with a small burst counter. The counter can be cleared, loaded from the address pins, stepped by one, or held. This lets a host stream a run of consecutive words after giving a single start address. Each port also chooses its own read latency: one clock in flow-through mode, or two clocks when the extra output register is selected. The port is selected only when both of its chip enables are active, so several instances can be stacked in depth with no outside decode. The output bus never floats. Instead, a valid flag marks the cycles that carry read data, and the bus reads zero at all other times.

The depth is set by `ADDR_W`, which defaults to 1K words and can be raised to 13 for 8K words. `SAME_CLK` states that both port clocks come from one source. With that setting, a same-word, same-edge write from both ports resolves in favour of port A.

Top module: `dpr_sync_ram`

## Requirements
- R1: While a port's reset is low, its burst counter is 0, its output word is 0 and its valid flag is low.
- R2: The burst counter takes one action at each edge, chosen in this priority order: clear (clr_n low) gives 0; load (ld_n low) gives the address pins; step (inc_n low) gives the current value plus one, with the top address wrapping to 0; otherwise the counter holds. The access address of a cycle is the counter value chosen at that edge.
- R3: A write happens only when the port is selected (ce0_n low and ce1 high) with we_n low. It stores to the access address at that edge. A write while the port is not selected leaves the array unchanged.
- R4: Bits 8:0 form the lower lane, enabled by lb_n low. Bits 17:9 form the upper lane, enabled by ub_n low. A write changes only the enabled lanes, and a read returns 0 in any lane that is not enabled.
- R5: With pipe low (flow-through), data read at edge k is on the output, with the valid flag high, from edge k until edge k+1.
- R6: With pipe high (pipelined), data read at edge k is on the output from edge k+1 until edge k+2.
- R7: A cycle that is not a read produces an output word of 0 with the valid flag low. This covers a port that is not selected, a read with oe_n high, and any write cycle.
- R8: The two ports work independently. Each can read or write any word, including the word the other port is using.
- R9: When both ports write the same word at the same edge, port A's data wins in every lane that both ports enable. Port B's data still lands in any lane that only port B enables.
- R10: A read that meets a write to the same word at the same edge returns the word's previous contents. The new data is seen from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pa_clk | input | 1 | Port A clock |
| pa_rst_n | input | 1 | Port A asynchronous reset, active low |
| pa_addr_i | input | ADDR_W | Port A load address |
| pa_ld_n | input | 1 | Port A counter load, active low |
| pa_inc_n | input | 1 | Port A counter step, active low |
| pa_clr_n | input | 1 | Port A counter clear, active low |
| pa_ce0_n | input | 1 | Port A chip enable, active low |
| pa_ce1 | input | 1 | Port A chip enable, active high |
| pa_we_n | input | 1 | Port A write select, low = write |
| pa_ub_n | input | 1 | Port A upper lane enable, active low |
| pa_lb_n | input | 1 | Port A lower lane enable, active low |
| pa_oe_n | input | 1 | Port A output enable, active low |
| pa_pipe | input | 1 | Port A latency select, 1 = pipelined |
| pa_d | input | 18 | Port A write data |
| pa_q | output | 18 | Port A read data |
| pa_q_vld | output | 1 | Port A read data valid |
| pb_clk | input | 1 | Port B clock |
| pb_rst_n | input | 1 | Port B asynchronous reset, active low |
| pb_addr_i | input | ADDR_W | Port B load address |
| pb_ld_n | input | 1 | Port B counter load, active low |
| pb_inc_n | input | 1 | Port B counter step, active low |
| pb_clr_n | input | 1 | Port B counter clear, active low |
| pb_ce0_n | input | 1 | Port B chip enable, active low |
| pb_ce1 | input | 1 | Port B chip enable, active high |
| pb_we_n | input | 1 | Port B write select, low = write |
| pb_ub_n | input | 1 | Port B upper lane enable, active low |
| pb_lb_n | input | 1 | Port B lower lane enable, active low |
| pb_oe_n | input | 1 | Port B output enable, active low |
| pb_pipe | input | 1 | Port B latency select, 1 = pipelined |
| pb_d | input | 18 | Port B write data |
| pb_q | output | 18 | Port B read data |
| pb_q_vld | output | 1 | Port B read data valid |

## Verification
The assertions watch port-level timing on every cycle: each branch of the counter priority, the zero-when-invalid output rule, and the one-cycle and two-cycle alignment of the valid flag with the read request. What the array holds can only be judged by scenarios that write and later read back. This covers lane merging, writes that are ignored when the port is not selected, port A winning a same-word write, and reads that return old data during a write. The bench shows these by comparing both ports against a behavioural model on every clock, including a long run of mixed random traffic.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    CTR_HOLD  = 2'd0,
    CTR_STEP  = 2'd1,
    CTR_LOAD  = 2'd2,
    CTR_CLEAR = 2'd3
  } ctr_op_e;

  // clear beats load beats step beats hold
  function automatic ctr_op_e ctr_decode(logic clr_n, logic ld_n, logic inc_n);
    if (!clr_n)      return CTR_CLEAR;
    else if (!ld_n)  return CTR_LOAD;
    else if (!inc_n) return CTR_STEP;
    else             return CTR_HOLD;
  endfunction

  // lane 1 = upper bits, lane 0 = lower bits
  function automatic logic [LANES-1:0] lane_enables(logic ub_n, logic lb_n);
    return {~ub_n, ~lb_n};
  endfunction

  function automatic logic [WORD_W-1:0] lane_bits(logic [LANES-1:0] en);
    logic [WORD_W-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*LANE_W +: LANE_W] = {LANE_W{en[l]}};
    return r;
  endfunction

  // per lane choose the bank that holds the newest write
  function automatic logic [WORD_W-1:0] lane_pick(logic [WORD_W-1:0] a_word,
                                                  logic [WORD_W-1:0] b_word,
                                                  logic [LANES-1:0] use_b);
    logic [WORD_W-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*LANE_W +: LANE_W] = use_b[l] ? b_word[l*LANE_W +: LANE_W]
                                       : a_word[l*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/dpr_addr_ctr.sv
module dpr_addr_ctr
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              ld_n,
  input  logic              inc_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [ADDR_W-1:0] addr_q
);
  ctr_op_e op;

  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(1);   // natural wrap at the top address
  endfunction

  always_comb begin
    op = ctr_decode(clr_n, ld_n, inc_n);
    unique case (op)
      CTR_CLEAR: addr_nxt = '0;
      CTR_LOAD:  addr_nxt = ext_addr;
      CTR_STEP:  addr_nxt = step_addr(addr_q);
      default:   addr_nxt = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_nxt;
endmodule

// File: rtl/dpr_bank.sv
module dpr_bank
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter bit INV    = 1'b0,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [WORD_W-1:0] din,
  input  logic [LANES-1:0]  peer_tog,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [WORD_W-1:0] a_word,
  output logic [WORD_W-1:0] b_word,
  output logic [LANES-1:0]  a_tog,
  output logic [LANES-1:0]  b_tog
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [LANES-1:0]  tog [DEPTH];

  // the owning port alone writes this bank; the toggle is set so that
  // (bank A toggle ^ bank B toggle) names the bank holding the newest lane
  always_ff @(posedge clk)
    for (int l = 0; l < LANES; l++)
      if (wr_lanes[l]) begin
        mem[wr_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
        tog[wr_addr][l]                  <= peer_tog[l] ^ INV;
      end

  assign a_word = mem[a_addr];
  assign b_word = mem[b_addr];
  assign a_tog  = tog[a_addr];
  assign b_tog  = tog[b_addr];
endmodule

// File: rtl/dpr_port.sv
module dpr_port
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ld_n,
  input  logic              inc_n,
  input  logic              clr_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              we_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  wr_lanes,
  output logic              rd_fire,
  output logic [WORD_W-1:0] q,
  output logic              q_vld
);
  logic              selected;
  logic [LANES-1:0]  lanes;
  logic [WORD_W-1:0] s1_q, s2_q;
  logic              s1_v, s2_v;

  dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .inc_n(inc_n),
    .ext_addr(ext_addr), .addr_nxt(acc_addr), .addr_q(addr_q)
  );

  assign selected = ~ce0_n & ce1;
  assign lanes    = lane_enables(ub_n, lb_n);
  assign wr_lanes = (selected & ~we_n) ? lanes : '0;
  assign rd_fire  = selected & we_n & ~oe_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0; s1_v <= 1'b0;
      s2_q <= '0; s2_v <= 1'b0;
    end else begin
      s1_q <= rd_fire ? (rd_word & lane_bits(lanes)) : '0;
      s1_v <= rd_fire;
      s2_q <= s1_q;
      s2_v <= s1_v;
    end

  assign q     = pipe ? s2_q : s1_q;
  assign q_vld = pipe ? s2_v : s1_v;
endmodule

// File: rtl/dpr_sync_ram.sv
module dpr_sync_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter bit SAME_CLK = 1'b1
) (
  input  logic              pa_clk,
  input  logic              pa_rst_n,
  input  logic [ADDR_W-1:0] pa_addr_i,
  input  logic              pa_ld_n,
  input  logic              pa_inc_n,
  input  logic              pa_clr_n,
  input  logic              pa_ce0_n,
  input  logic              pa_ce1,
  input  logic              pa_we_n,
  input  logic              pa_ub_n,
  input  logic              pa_lb_n,
  input  logic              pa_oe_n,
  input  logic              pa_pipe,
  input  logic [17:0]       pa_d,
  output logic [17:0]       pa_q,
  output logic              pa_q_vld,
  input  logic              pb_clk,
  input  logic              pb_rst_n,
  input  logic [ADDR_W-1:0] pb_addr_i,
  input  logic              pb_ld_n,
  input  logic              pb_inc_n,
  input  logic              pb_clr_n,
  input  logic              pb_ce0_n,
  input  logic              pb_ce1,
  input  logic              pb_we_n,
  input  logic              pb_ub_n,
  input  logic              pb_lb_n,
  input  logic              pb_oe_n,
  input  logic              pb_pipe,
  input  logic [17:0]       pb_d,
  output logic [17:0]       pb_q,
  output logic              pb_q_vld
);
  logic [ADDR_W-1:0] pa_acc_addr, pb_acc_addr, pa_addr_q, pb_addr_q;
  logic [LANES-1:0]  pa_wr_lanes, pb_wr_lanes, pb_blocked, pb_wr_eff;
  logic              pa_rd_fire, pb_rd_fire;
  logic [WORD_W-1:0] pa_word, pb_word;
  logic [WORD_W-1:0] bka_wa, bka_wb, bkb_wa, bkb_wb;
  logic [LANES-1:0]  bka_ta, bka_tb, bkb_ta, bkb_tb;

  dpr_port #(.ADDR_W(ADDR_W)) u_pa (
    .clk(pa_clk), .rst_n(pa_rst_n), .ext_addr(pa_addr_i), .ld_n(pa_ld_n),
    .inc_n(pa_inc_n), .clr_n(pa_clr_n), .ce0_n(pa_ce0_n), .ce1(pa_ce1),
    .we_n(pa_we_n), .ub_n(pa_ub_n), .lb_n(pa_lb_n), .oe_n(pa_oe_n),
    .pipe(pa_pipe), .rd_word(pa_word), .acc_addr(pa_acc_addr),
    .addr_q(pa_addr_q), .wr_lanes(pa_wr_lanes), .rd_fire(pa_rd_fire),
    .q(pa_q), .q_vld(pa_q_vld)
  );

  dpr_port #(.ADDR_W(ADDR_W)) u_pb (
    .clk(pb_clk), .rst_n(pb_rst_n), .ext_addr(pb_addr_i), .ld_n(pb_ld_n),
    .inc_n(pb_inc_n), .clr_n(pb_clr_n), .ce0_n(pb_ce0_n), .ce1(pb_ce1),
    .we_n(pb_we_n), .ub_n(pb_ub_n), .lb_n(pb_lb_n), .oe_n(pb_oe_n),
    .pipe(pb_pipe), .rd_word(pb_word), .acc_addr(pb_acc_addr),
    .addr_q(pb_addr_q), .wr_lanes(pb_wr_lanes), .rd_fire(pb_rd_fire),
    .q(pb_q), .q_vld(pb_q_vld)
  );

  // same-edge, same-word write: port B yields its shared lanes to port A
  generate
    if (SAME_CLK) begin : g_arb
      assign pb_blocked = (pa_acc_addr == pb_acc_addr) ? (pa_wr_lanes & pb_wr_lanes) : '0;
    end else begin : g_noarb
      assign pb_blocked = '0;
    end
  endgenerate
  assign pb_wr_eff = pb_wr_lanes & ~pb_blocked;

  dpr_bank #(.ADDR_W(ADDR_W), .INV(1'b0)) u_bank_a (
    .clk(pa_clk), .wr_addr(pa_acc_addr), .wr_lanes(pa_wr_lanes), .din(pa_d),
    .peer_tog(bkb_ta), .a_addr(pa_acc_addr), .b_addr(pb_acc_addr),
    .a_word(bka_wa), .b_word(bka_wb), .a_tog(bka_ta), .b_tog(bka_tb)
  );

  dpr_bank #(.ADDR_W(ADDR_W), .INV(1'b1)) u_bank_b (
    .clk(pb_clk), .wr_addr(pb_acc_addr), .wr_lanes(pb_wr_eff), .din(pb_d),
    .peer_tog(bka_tb), .a_addr(pa_acc_addr), .b_addr(pb_acc_addr),
    .a_word(bkb_wa), .b_word(bkb_wb), .a_tog(bkb_ta), .b_tog(bkb_tb)
  );

  assign pa_word = lane_pick(bka_wa, bkb_wa, bka_ta ^ bkb_ta);
  assign pb_word = lane_pick(bka_wb, bkb_wb, bka_tb ^ bkb_tb);
endmodule

// File: rtl/dpr_sync_ram_chk.sv
module dpr_sync_ram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              pa_clk,
  input logic              pa_rst_n,
  input logic              pa_clr_n,
  input logic              pa_ld_n,
  input logic              pa_inc_n,
  input logic [ADDR_W-1:0] pa_addr_i,
  input logic [ADDR_W-1:0] pa_addr_q,
  input logic              pa_pipe,
  input logic              pa_rd_fire,
  input logic [17:0]       pa_q,
  input logic              pa_q_vld,
  input logic              pb_clk,
  input logic              pb_rst_n,
  input logic [17:0]       pb_q,
  input logic              pb_q_vld
);
  logic [1:0] settle;   // edges since reset, saturating
  always_ff @(posedge pa_clk or negedge pa_rst_n)
    if (!pa_rst_n)        settle <= 2'd0;
    else if (settle != 3) settle <= settle + 2'd1;

  a_r2_clear: assert property (@(posedge pa_clk) disable iff (!pa_rst_n)
    !pa_clr_n |=> pa_addr_q == '0);
  a_r2_load: assert property (@(posedge pa_clk) disable iff (!pa_rst_n)
    (pa_clr_n && !pa_ld_n) |=> pa_addr_q == $past(pa_addr_i));
  a_r2_step: assert property (@(posedge pa_clk) disable iff (!pa_rst_n)
    (pa_clr_n && pa_ld_n && !pa_inc_n) |=> pa_addr_q == ADDR_W'($past(pa_addr_q) + ADDR_W'(1)));
  a_r2_hold: assert property (@(posedge pa_clk) disable iff (!pa_rst_n)
    (pa_clr_n && pa_ld_n && pa_inc_n) |=> $stable(pa_addr_q));
  a_r7_idle_a: assert property (@(posedge pa_clk) disable iff (!pa_rst_n)
    !pa_q_vld |-> pa_q == '0);
  a_r7_idle_b: assert property (@(posedge pb_clk) disable iff (!pb_rst_n)
    !pb_q_vld |-> pb_q == '0);
  a_r5_flow_lat: assert property (@(posedge pa_clk) disable iff (!pa_rst_n)
    (!pa_pipe && settle >= 2'd1) |-> pa_q_vld == $past(pa_rd_fire));
  a_r6_pipe_lat: assert property (@(posedge pa_clk) disable iff (!pa_rst_n)
    (pa_pipe && settle >= 2'd2) |-> pa_q_vld == $past(pa_rd_fire, 2));
endmodule

bind dpr_sync_ram dpr_sync_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .pa_clk(pa_clk), .pa_rst_n(pa_rst_n), .pa_clr_n(pa_clr_n), .pa_ld_n(pa_ld_n),
  .pa_inc_n(pa_inc_n), .pa_addr_i(pa_addr_i), .pa_addr_q(pa_addr_q),
  .pa_pipe(pa_pipe), .pa_rd_fire(pa_rd_fire), .pa_q(pa_q), .pa_q_vld(pa_q_vld),
  .pb_clk(pb_clk), .pb_rst_n(pb_rst_n), .pb_q(pb_q), .pb_q_vld(pb_q_vld)
);

// File: tb/tb_dpr_sync_ram.sv
module tb_dpr_sync_ram;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic ld_n, inc_n, clr_n, ce0_n, ce1, we_n, ub_n, lb_n, oe_n, pipe;
    logic [AW-1:0] a;
    logic [17:0] d;
  } pin_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  pin_t pa, pb;
  logic [17:0] pa_q, pb_q;
  logic pa_q_vld, pb_q_vld;
  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpr_sync_ram #(.ADDR_W(AW)) dut (
    .pa_clk(clk), .pa_rst_n(rst_n), .pa_addr_i(pa.a), .pa_ld_n(pa.ld_n),
    .pa_inc_n(pa.inc_n), .pa_clr_n(pa.clr_n), .pa_ce0_n(pa.ce0_n), .pa_ce1(pa.ce1),
    .pa_we_n(pa.we_n), .pa_ub_n(pa.ub_n), .pa_lb_n(pa.lb_n), .pa_oe_n(pa.oe_n),
    .pa_pipe(pa.pipe), .pa_d(pa.d), .pa_q(pa_q), .pa_q_vld(pa_q_vld),
    .pb_clk(clk), .pb_rst_n(rst_n), .pb_addr_i(pb.a), .pb_ld_n(pb.ld_n),
    .pb_inc_n(pb.inc_n), .pb_clr_n(pb.clr_n), .pb_ce0_n(pb.ce0_n), .pb_ce1(pb.ce1),
    .pb_we_n(pb.we_n), .pb_ub_n(pb.ub_n), .pb_lb_n(pb.lb_n), .pb_oe_n(pb.oe_n),
    .pb_pipe(pb.pipe), .pb_d(pb.d), .pb_q(pb_q), .pb_q_vld(pb_q_vld)
  );

  // ---------------- behavioural reference model ----------------
  logic [17:0] mdl_mem [int];
  int          ctr [2];
  logic [17:0] s1q [2], s2q [2];
  bit          s1v [2], s2v [2];

  function automatic logic [17:0] lmask(logic ub_n, logic lb_n);
    return {{9{~ub_n}}, {9{~lb_n}}};
  endfunction

  function automatic int next_ctr(int cur, pin_t p);
    if (!p.clr_n) return 0;
    if (!p.ld_n)  return int'(p.a);
    if (!p.inc_n) return (cur + 1) % DEPTH;
    return cur;
  endfunction

  function automatic logic [17:0] mget(int a);
    return mdl_mem.exists(a) ? mdl_mem[a] : 18'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    pin_t pp [2];
    int na [2];
    logic [17:0] rd [2];
    bit rv [2];
    logic [17:0] m;
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        ctr[p] = 0; s1q[p] = 0; s2q[p] = 0; s1v[p] = 0; s2v[p] = 0;
      end
    end else begin
      pp[0] = pa; pp[1] = pb;
      for (int p = 0; p < 2; p++) begin   // reads see the word before this edge's writes
        na[p] = next_ctr(ctr[p], pp[p]);
        rv[p] = !pp[p].ce0_n && pp[p].ce1 && pp[p].we_n && !pp[p].oe_n;
        rd[p] = rv[p] ? (mget(na[p]) & lmask(pp[p].ub_n, pp[p].lb_n)) : 18'h0;
      end
      for (int p = 1; p >= 0; p--) begin  // B first so A overwrites: A wins
        if (!pp[p].ce0_n && pp[p].ce1 && !pp[p].we_n) begin
          m = lmask(pp[p].ub_n, pp[p].lb_n);
          mdl_mem[na[p]] = (mget(na[p]) & ~m) | (pp[p].d & m);
        end
      end
      for (int p = 0; p < 2; p++) begin
        s2q[p] = s1q[p]; s2v[p] = s1v[p];
        s1q[p] = rd[p];  s1v[p] = rv[p];
        ctr[p] = na[p];
      end
    end
  end

  // ---------------- checking ----------------
  task automatic cmp_port(int p, logic [17:0] q, logic v, pin_t pin);
    logic [17:0] eq;
    bit ev;
    eq = pin.pipe ? s2q[p] : s1q[p];
    ev = pin.pipe ? s2v[p] : s1v[p];
    checks++;
    if (q !== eq || v !== ev) begin
      errors++;
      $display("FAIL %s port %0d actual q=%h vld=%b expected q=%h vld=%b", tag, p, q, v, eq, ev);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cmp_port(0, pa_q, pa_q_vld, pa);
    cmp_port(1, pb_q, pb_q_vld, pb);
  endtask

  task automatic expect_word(string t, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic pin_t f_idle();
    pin_t r;
    r = '0;
    r.ld_n = 1; r.inc_n = 1; r.clr_n = 1; r.ce0_n = 1; r.ce1 = 0;
    r.we_n = 1; r.ub_n = 1; r.lb_n = 1; r.oe_n = 1; r.pipe = 0;
    return r;
  endfunction

  function automatic pin_t f_wr(bit load, int a, logic [17:0] d, logic ub_n, logic lb_n);
    pin_t r;
    r = f_idle();
    r.ce0_n = 0; r.ce1 = 1; r.we_n = 0; r.ub_n = ub_n; r.lb_n = lb_n;
    r.ld_n = ~load; r.inc_n = load; r.a = AW'(a); r.d = d;
    return r;
  endfunction

  function automatic pin_t f_rd(bit load, int a, logic pipe, logic ub_n, logic lb_n);
    pin_t r;
    r = f_idle();
    r.ce0_n = 0; r.ce1 = 1; r.oe_n = 0; r.ub_n = ub_n; r.lb_n = lb_n; r.pipe = pipe;
    r.ld_n = ~load; r.inc_n = load; r.a = AW'(a);
    return r;
  endfunction

  function automatic logic [17:0] pat(int i);
    return {i[8:0], ~i[8:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog run hung: actual still running, expected finished");
    finish_run();
  end

  initial begin
    pa = f_idle(); pb = f_idle();
    // R1 reset state
    tag = "R1";
    repeat (3) step();
    expect_word("R1 reset q A", pa_q, 18'h0);
    expect_word("R1 reset vld A", {17'h0, pa_q_vld}, 18'h0);
    expect_word("R1 reset q B", pb_q, 18'h0);
    rst_n = 1'b1;
    step();

    // R3 burst write through the counter
    tag = "R3";
    for (int i = 0; i < 64; i++) begin
      pa = f_wr(i == 0, 0, pat(i), 0, 0);
      step();
    end
    pa = f_idle(); step();

    // R5 flow-through burst read on B
    tag = "R5";
    for (int i = 0; i < 8; i++) begin
      pb = f_rd(i == 0, 0, 0, 0, 0);
      step();
    end
    pb = f_idle(); step();

    // R6 pipelined burst read on A
    tag = "R6";
    for (int i = 0; i < 8; i++) begin
      pa = f_rd(i == 0, 4, 1, 0, 0);
      step();
    end
    pa = f_idle(); pa.pipe = 1; step(); step();
    pa = f_idle(); step();

    // R8 both ports on the same word, different latencies
    tag = "R8";
    pa = f_rd(1, 10, 1, 0, 0); pb = f_rd(1, 10, 0, 0, 0); step();
    pa = f_wr(1, 11, 18'h2468A, 0, 0); pb = f_rd(1, 12, 0, 0, 0); step();
    pa = f_idle(); pa.pipe = 1; pb = f_rd(1, 11, 0, 0, 0); step();
    expect_word("R8 B reads A's word", pb_q, 18'h2468A);
    pa = f_idle(); pb = f_idle(); step();

    // R4 byte lanes
    tag = "R4";
    pa = f_wr(1, 20, 18'h3FFFF, 1, 0); step();
    pa = f_idle(); pb = f_rd(1, 20, 0, 0, 1); step();
    expect_word("R4 upper lane only", pb_q, {pat(20)[17:9], 9'h0});
    pb = f_rd(1, 20, 0, 1, 0); step();
    expect_word("R4 lower lane only", pb_q, 18'h001FF);
    pb = f_rd(1, 20, 0, 0, 0); step();
    pb = f_idle(); step();

    // R7 idle output cases; R3 write while not selected
    tag = "R7";
    pb = f_rd(1, 5, 0, 0, 0); pb.oe_n = 1; step();
    pb = f_rd(1, 5, 0, 0, 0); pb.ce1 = 0; step();
    pb = f_rd(1, 5, 0, 0, 0); pb.ce0_n = 1; step();
    pb = f_wr(1, 50, 18'h11111, 0, 0); step();
    expect_word("R7 write cycle vld", {17'h0, pb_q_vld}, 18'h0);
    tag = "R3";
    pb = f_wr(1, 21, 18'h0, 0, 0); pb.ce1 = 0; step();
    pb = f_rd(1, 21, 0, 0, 0); step();
    expect_word("R3 deselected write ignored", pb_q, pat(21));
    pb = f_idle(); step();

    // R9 same-word, same-edge writes
    tag = "R9";
    pa = f_wr(1, 40, 18'h15555, 0, 0); pb = f_wr(1, 40, 18'h2AAAA, 0, 0); step();
    pa = f_wr(1, 41, 18'h3FFFF, 1, 0); pb = f_wr(1, 41, 18'h00000, 0, 0); step();
    pa = f_rd(1, 40, 0, 0, 0); pb = f_idle(); step();
    expect_word("R9 port A wins", pa_q, 18'h15555);
    pa = f_rd(1, 41, 0, 0, 0); step();
    expect_word("R9 lane mix", pa_q, 18'h001FF);
    pa = f_idle(); step();

    // R10 read meets write
    tag = "R10";
    pa = f_wr(1, 42, 18'h12345, 0, 0); pb = f_rd(1, 42, 0, 0, 0); step();
    expect_word("R10 old data", pb_q, pat(42));
    pa = f_idle(); step();
    expect_word("R10 new data later", pb_q, 18'h12345);
    pb = f_idle(); step();

    // R2 counter priority, hold and wrap
    tag = "R2";
    pa = f_wr(1, 50, 18'h0ABCD, 0, 0); pa.clr_n = 0; step();
    pa = f_wr(1, 60, 18'h33333, 0, 0); pa.inc_n = 0; step();
    pa = f_wr(0, 0, 18'h30303, 0, 0); pa.inc_n = 1; step();
    pa = f_wr(1, DEPTH - 1, 18'h11111, 0, 0); step();
    pa = f_wr(0, 0, 18'h22222, 0, 0); step();
    pa = f_idle(); pb = f_rd(1, 0, 0, 0, 0); step();
    expect_word("R2 wrap to zero", pb_q, 18'h22222);
    pb = f_rd(1, DEPTH - 1, 0, 0, 0); step();
    expect_word("R2 top address", pb_q, 18'h11111);
    pb = f_rd(1, 60, 0, 0, 0); step();
    expect_word("R2 load beats step, hold", pb_q, 18'h30303);
    pb = f_rd(1, 61, 0, 0, 0); step();
    expect_word("R2 neighbour untouched", pb_q, pat(61));
    pb = f_idle(); step();

    // R8 mixed random traffic on both ports
    tag = "R8";
    for (int n = 0; n < 3000; n++) begin
      pin_t r [2];
      for (int p = 0; p < 2; p++) begin
        r[p] = f_idle();
        r[p].ld_n  = 1'($urandom % 2);
        r[p].inc_n = 1'($urandom % 2);
        r[p].clr_n = ($urandom % 16) != 0;
        r[p].ce0_n = ($urandom % 5) == 0;
        r[p].ce1   = ($urandom % 5) != 0;
        r[p].we_n  = 1'($urandom % 2);
        r[p].ub_n  = ($urandom % 3) == 0;
        r[p].lb_n  = ($urandom % 3) == 0;
        r[p].oe_n  = ($urandom % 5) == 0;
        r[p].pipe  = 1'($urandom % 2);
        r[p].a     = AW'($urandom % 32);
        r[p].d     = 18'($urandom);
      end
      pa = r[0]; pb = r[1];
      step();
    end
    pa = f_idle(); pb = f_idle(); step(); step();
    finish_run();
  end
endmodule